// File: doc/BRIEF.md
# I/O channel sequence arbiter

This block hands out two shared channel resources to the major channel sequences. The first resource is a poll group. The second is a service group. An interrupt-poll request starts a polling sequence on the poll group. When polling completes, the poll group keeps its result and waits for the service group, where an interrupt-acceptance step runs. The poll group is handed back in the same cycle that acceptance takes the service group. A new poll can therefore run while service work is still under way.

A cycle-steal burst takes the service group and keeps every other sequence out while it runs. Polling is allowed again from the burst's final transfer onward, so a pending poll can run alongside that last transfer. The block sees only request, done and final-transfer strobes. It drives a one-hot grant vector and a busy flag for each resource.

Top module: `chan_seq_arb`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) leaves `pg_gnt`, `sg_gnt`, `pg_busy` and `sg_busy` all zero and discards any pending poll request.
- R2: A poll request seen while the poll group is idle and polling is allowed makes `pg_gnt` equal 2'b01 (bit 0 = polling) after that edge.
- R3: A poll request that cannot start at once is held pending and not dropped. It starts at the first edge where the poll group is free and polling is allowed, including the edge where the poll group is handed to acceptance.
- R4: `poll_done` while polling makes `pg_gnt` equal 2'b10 (bit 1 = result held) at the next edge. The result stays held for as long as the service group is occupied.
- R5: A held result with the service group idle and no burst taken at that edge makes `sg_gnt` equal 2'b01 (bit 0 = acceptance). At the same edge the poll group leaves the held state.
- R6: `acc_done` during acceptance frees the service group (`sg_gnt` 2'b00) at the next edge. Until then, acceptance keeps the service group.
- R7: `burst_req` is taken when the service group is idle and the poll group is not polling, giving `sg_gnt` equal 2'b10 (bit 1 = burst). When a burst and a waiting acceptance are both eligible, the burst wins and the result stays held. A burst request made while polling runs is not taken.
- R8: While a burst runs and its final transfer has not been marked, no poll starts and no acceptance is granted.
- R9: `burst_last` during a burst lets polling start at that same edge. The burst grant remains until `burst_done` is seen after the final transfer is marked.
- R10: Each grant vector is one-hot or zero, and each busy flag is high exactly when its grant is nonzero. A done strobe outside its own phase has no effect, including `burst_done` before `burst_last`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| poll_req | input | 1 | Interrupt-poll request strobe |
| poll_done | input | 1 | Polling sequence complete |
| acc_done | input | 1 | Interrupt acceptance complete |
| burst_req | input | 1 | Cycle-steal burst request |
| burst_last | input | 1 | Current burst transfer is the final one |
| burst_done | input | 1 | Final burst transfer complete |
| pg_gnt | output | 2 | Poll group grant: bit 0 polling, bit 1 result held |
| sg_gnt | output | 2 | Service group grant: bit 0 acceptance, bit 1 burst |
| pg_busy | output | 1 | Poll group occupied |
| sg_busy | output | 1 | Service group occupied |

## Verification
Three collisions matter here. In the first, a burst request and a held poll result both become eligible for an idle service group in the same cycle. In the second, acceptance takes the service group at the same edge as a pending poll restarts the poll group. In the third, the final-transfer strobe releases polling at the same edge as a held-back poll request is waiting. Directed sequences set up each of these collisions on purpose and check both grant vectors right after the edge. A long pseudo-random sweep over all six input strobes, with occasional resets, is compared cycle by cycle against a state model kept in the bench.

// File: rtl/chan_seq_arb.sv
module chan_seq_arb (
  input  logic       clk,
  input  logic       rst,
  input  logic       poll_req,
  input  logic       poll_done,
  input  logic       acc_done,
  input  logic       burst_req,
  input  logic       burst_last,
  input  logic       burst_done,
  output logic [1:0] pg_gnt,
  output logic [1:0] sg_gnt,
  output logic       pg_busy,
  output logic       sg_busy
);

  typedef enum logic [1:0] {PG_IDLE, PG_POLL, PG_HOLD} pg_t;
  typedef enum logic [1:0] {SG_IDLE, SG_ACC, SG_BURST, SG_LAST} sg_t;

  pg_t  pg_q;
  sg_t  sg_q;
  logic pend_q;

  logic want_poll, burst_go, acc_go, poll_ok, poll_go;

  assign want_poll = pend_q | poll_req;
  assign burst_go  = (sg_q == SG_IDLE) && burst_req && (pg_q != PG_POLL);
  assign acc_go    = (pg_q == PG_HOLD) && (sg_q == SG_IDLE) && !burst_go;
  assign poll_ok   = !((sg_q == SG_BURST) && !burst_last) && !burst_go;
  assign poll_go   = want_poll && poll_ok && ((pg_q == PG_IDLE) || acc_go);

  always_ff @(posedge clk) begin
    if (rst) begin
      pg_q   <= PG_IDLE;
      pend_q <= 1'b0;
    end else begin
      pend_q <= want_poll && !poll_go;
      if (poll_go)
        pg_q <= PG_POLL;
      else if (acc_go)
        pg_q <= PG_IDLE;
      else if ((pg_q == PG_POLL) && poll_done)
        pg_q <= PG_HOLD;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      sg_q <= SG_IDLE;
    else begin
      case (sg_q)
        SG_IDLE:  if (burst_go) sg_q <= SG_BURST;
                  else if (acc_go) sg_q <= SG_ACC;
        SG_ACC:   if (acc_done) sg_q <= SG_IDLE;
        SG_BURST: if (burst_last) sg_q <= SG_LAST;
        default:  if (burst_done) sg_q <= SG_IDLE;
      endcase
    end
  end

  assign pg_gnt  = {pg_q == PG_HOLD, pg_q == PG_POLL};
  assign sg_gnt  = {(sg_q == SG_BURST) || (sg_q == SG_LAST), sg_q == SG_ACC};
  assign pg_busy = pg_q != PG_IDLE;
  assign sg_busy = sg_q != SG_IDLE;

endmodule

// File: rtl/chan_seq_arb_chk.sv
module chan_seq_arb_chk (
  input logic       clk,
  input logic       rst,
  input logic       acc_done,
  input logic       burst_req,
  input logic       burst_last,
  input logic [1:0] pg_gnt,
  input logic [1:0] sg_gnt
);

  logic tail_q;

  always_ff @(posedge clk) begin
    if (rst || !sg_gnt[1])
      tail_q <= 1'b0;
    else if (burst_last)
      tail_q <= 1'b1;
  end

  AST_PG_ONEHOT: assert property (@(posedge clk) disable iff (rst) $onehot0(pg_gnt)); // R10
  AST_SG_ONEHOT: assert property (@(posedge clk) disable iff (rst) $onehot0(sg_gnt)); // R10
  AST_HOLD_WHILE_SG_BUSY: assert property (@(posedge clk) disable iff (rst)
    (pg_gnt[1] && sg_gnt != 2'b00) |=> pg_gnt[1]); // R4
  AST_ACC_RELEASES_PG: assert property (@(posedge clk) disable iff (rst)
    $rose(sg_gnt[0]) |-> (!pg_gnt[1] && $past(pg_gnt[1]))); // R5
  AST_ACC_KEEPS_SG: assert property (@(posedge clk) disable iff (rst)
    (sg_gnt[0] && !acc_done) |=> sg_gnt[0]); // R6
  AST_BURST_WINS: assert property (@(posedge clk) disable iff (rst)
    (pg_gnt[1] && sg_gnt == 2'b00 && burst_req) |=> (sg_gnt == 2'b10 && pg_gnt[1])); // R7
  AST_NO_POLL_MID_BURST: assert property (@(posedge clk) disable iff (rst)
    (sg_gnt[1] && $rose(pg_gnt[0])) |-> tail_q); // R8

endmodule

bind chan_seq_arb chan_seq_arb_chk i_chk (.*);

// File: tb/test_chan_seq_arb.sv
module test_chan_seq_arb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic poll_req = 0, poll_done = 0, acc_done = 0;
  logic burst_req = 0, burst_last = 0, burst_done = 0;
  logic [1:0] pg_gnt, sg_gnt;
  logic pg_busy, sg_busy;
  int n_chk = 0, n_bad = 0;
  bit  done_flag = 0;

  always #5 clk = ~clk;

  chan_seq_arb i_chan_seq_arb (.*);

  // v = {burst_done, burst_last, burst_req, acc_done, poll_done, poll_req}
  task automatic step(input logic [5:0] v);
    {burst_done, burst_last, burst_req, acc_done, poll_done, poll_req} = v;
    @(posedge clk);
    #2;
  endtask

  task automatic chk(input string tag, input logic [1:0] a, input logic [1:0] e);
    n_chk++;
    if (a !== e) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b", tag, a, e);
    end
  endtask

  task automatic chk2(input string tag, input logic [1:0] ep, input logic [1:0] es);
    chk({tag, " pg_gnt"}, pg_gnt, ep);
    chk({tag, " sg_gnt"}, sg_gnt, es);
  endtask

  localparam logic [5:0] PR = 6'd1, PD = 6'd2, AD = 6'd4, BR = 6'd8, BL = 6'd16, BD = 6'd32;

  int mpg, msg;
  bit mpend;

  task automatic model(input logic [5:0] v, input bit r);
    bit want, bgo, ago, ok, pgo;
    if (r) begin mpg = 0; msg = 0; mpend = 0; return; end
    want = mpend | v[0];
    bgo  = (msg == 0) && v[3] && (mpg != 1);
    ago  = (mpg == 2) && (msg == 0) && !bgo;
    ok   = !((msg == 2) && !v[4]) && !bgo;
    pgo  = want && ok && ((mpg == 0) || ago);
    mpend = want && !pgo;
    if (pgo) mpg = 1; else if (ago) mpg = 0; else if (mpg == 1 && v[1]) mpg = 2;
    if (bgo) msg = 2;
    else if (ago) msg = 1;
    else if (msg == 1 && v[2]) msg = 0;
    else if (msg == 2 && v[4]) msg = 3;
    else if (msg == 3 && v[5]) msg = 0;
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [15:0] lf;
    #1;
    rst = 1; step(PR); step(PR | BR);
    chk2("R1 reset", 2'b00, 2'b00);
    chk("R1 busy", {pg_busy, sg_busy}, 2'b00);
    rst = 0;
    step(0);
    chk("R1 pending cleared", pg_gnt, 2'b00);

    step(PR);        chk2("R2 poll start", 2'b01, 2'b00);
    chk("R10 busy", {pg_busy, sg_busy}, 2'b10);
    step(PR);        chk2("R3 pend while polling", 2'b01, 2'b00);
    step(PD);        chk2("R4 result held", 2'b10, 2'b00);
    step(0);         chk2("R5 accept and R3 restart", 2'b01, 2'b01);
    step(PD);        chk2("R4 hold behind service", 2'b10, 2'b01);
    step(0);         chk2("R4 still held", 2'b10, 2'b01);
    step(AD);        chk2("R6 acceptance done", 2'b10, 2'b00);
    step(BR);        chk2("R7 burst beats acceptance", 2'b10, 2'b10);
    step(PR);        chk2("R8 no accept in burst", 2'b10, 2'b10);
    step(PD | AD);   chk2("R10 stray done ignored", 2'b10, 2'b10);
    step(BD);        chk2("R10 early burst_done ignored", 2'b10, 2'b10);
    step(BL);        chk2("R9 final transfer", 2'b10, 2'b10);
    step(BD);        chk2("R9 burst released", 2'b10, 2'b00);
    step(0);         chk2("R3 pending poll after accept", 2'b01, 2'b01);

    rst = 1; step(0); rst = 0;
    step(BR);        chk2("R7 burst taken", 2'b00, 2'b10);
    step(PR);        chk2("R8 poll held in burst", 2'b00, 2'b10);
    step(0);         chk2("R8 still held", 2'b00, 2'b10);
    step(BL);        chk2("R9 poll with last transfer", 2'b01, 2'b10);
    step(BR);        chk2("R9 burst grant stays", 2'b01, 2'b10);
    step(BD);        chk2("R9 burst done", 2'b01, 2'b00);
    step(BR);        chk2("R7 no burst while polling", 2'b01, 2'b00);
    step(PD);        chk2("R4 held", 2'b10, 2'b00);
    step(0);         chk2("R5 release without pending", 2'b00, 2'b01);
    chk("R10 busy flags", {pg_busy, sg_busy}, 2'b01);

    rst = 1; step(0); rst = 0;
    model(0, 1);
    lf = 16'hACE1;
    for (int i = 0; i < 6000; i++) begin
      logic [5:0] v;
      bit r;
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      v = lf[5:0] & lf[11:6];
      r = (lf[15:11] == 5'd0);
      rst = r;
      step(v);
      model(v, r);
      chk2("R10 sweep", mpg == 1 ? 2'b01 : mpg == 2 ? 2'b10 : 2'b00,
           msg == 1 ? 2'b01 : msg >= 2 ? 2'b10 : 2'b00);
    end
    rst = 0;
    finish_run();
  end
endmodule